// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds the integer register file of a processor whose procedure calls switch register sets instead of saving registers to memory. The physical storage is a ring of windows plus a small global bank. Each window has an incoming parameter area, a local area and an outgoing temporary area. The temporary area of one window is the same storage as the parameter area of the next deeper window, so a caller's outgoing arguments appear in the callee's parameter registers with no copying. A logical register number (0 to 31) is translated through the current window pointer into a physical index. The block offers two combinational read ports and one write port.

A call moves the current window pointer one step forward around the ring, and a return moves it one step back. A saved window pointer marks the window that was last written out to memory. When a call would land on the saved window, the ring is full. The block then raises an overflow trap and streams the oldest live window out through a valid/ready spill port before it completes the call. When a return would land on the saved window, the caller's window is not resident. The block then raises an underflow trap, takes that window back in through a valid/ready fill port, and then completes the return. The memory behind the spill and fill ports, and any trap software, lie outside this block.

The controller is a three-state machine:
- `ST_IDLE` serves reads, writes, calls and returns.
- `ST_SPILL` streams a window out.
- `ST_FILL` takes a window in.

Transitions:
- `ST_IDLE` goes to `ST_SPILL` on a call that overflows.
- `ST_IDLE` goes to `ST_FILL` on a return that underflows, when no call is asserted.
- `ST_SPILL` goes back to `ST_IDLE` when the sixteenth word is accepted.
- `ST_FILL` goes back to `ST_IDLE` when the sixteenth word is accepted.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 8–15 address the parameter area, and 16–23 the local area, of the window selected by the current window pointer.
- R2: Logical register 0 always reads as zero, and a write to it is discarded.
- R3: After reset the windows are used modulo 8. A call that does not overflow advances `cwp_o` by one. A return that does not underflow moves `cwp_o` back by one. Neither changes `swp_o`.
- R4: Logical registers 1–7 are global registers: the same storage is seen from every window, and it never moves with calls or returns.
- R5: A call made while (`cwp_o`+1) mod 8 equals `swp_o` starts a spill. In the next cycle, `ovf_trap_o` is high for exactly one cycle and `spill_valid_o` rises. The block then presents the 16 words of window (`swp_o`+1) mod 8 in the order: parameters 0–7, then locals 0–7. Each word is held until `spill_ready_i` accepts it. After the sixteenth word is accepted, `cwp_o` and `swp_o` each advance by one.
- R6: A return made while (`cwp_o`−1) mod 8 equals `swp_o` starts a fill. In the next cycle, `unf_trap_o` is high for exactly one cycle and `fill_ready_o` rises. The block then writes 16 accepted words into window `swp_o`, in the order: parameters 0–7, then locals 0–7. After the sixteenth word, `cwp_o` and `swp_o` each step back by one.
- R7: `busy_o` is high exactly while a spill or fill is in progress. During that time, calls, returns and writes on the user port are ignored.
- R8: When call and return are asserted together, the call wins and the return is dropped. A write in the same cycle as a call or return uses the window in effect before the pointer moves.
- R9: Reset leaves `cwp_o` = 0, `swp_o` = 7, `busy_o` low, no trap, and every register reading zero.
- R10: The two read ports are independent and combinational: each data output follows its own register number in the same cycle.
- R11: Logical registers 24–31 address the parameter area of window (`cwp_o`+1) mod 8. A value written there before a call reads back in registers 8–15 after the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call request |
| ret_i | input | 1 | Procedure return request |
| wr_en_i | input | 1 | Register write enable |
| wr_reg_i | input | 5 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| rd0_reg_i | input | 5 | Logical register for read port 0 |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_reg_i | input | 5 | Logical register for read port 1 |
| rd1_data_o | output | 32 | Read port 1 data |
| busy_o | output | 1 | Spill or fill in progress |
| ovf_trap_o | output | 1 | One-cycle overflow trap pulse |
| unf_trap_o | output | 1 | One-cycle underflow trap pulse |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |
| spill_valid_o | output | 1 | Spill word valid |
| spill_ready_i | input | 1 | Spill word accepted |
| spill_data_o | output | 32 | Spill word |
| fill_valid_i | input | 1 | Fill word valid |
| fill_ready_o | output | 1 | Fill port ready |
| fill_data_i | input | 32 | Fill word |

## Verification
The hardest situation to reach is an underflow whose refilled window must carry exactly the values that an earlier overflow sent out. This needs a call chain deeper than the ring, so that several windows are spilled, followed by an unwinding past the point where those spills happened. The stimulus writes distinct values into the locals and temporaries at every level of a twelve-deep call chain, then returns fourteen times. The bench keeps every spilled word on a stack and replays the most recent sixteen on each fill, and it toggles both handshakes so that stalled beats occur mid-transfer. Calls, returns and writes are also driven during every busy cycle, and a pseudo-random phase mixes simultaneous call, return and write requests.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPILL,
        ST_FILL
    } win_state_t;

    // Number of register areas seen by a logical register number
    localparam int N_AREAS = 4;

endpackage

// File: rtl/regwin_map.sv
`timescale 1ns/1ps
// Logical register number to physical storage index.
// Physical layout: globals at 0..AREA-1, then per window
// parameters followed by locals (2*AREA entries per window).
module regwin_map #(
    parameter int NWIN = 8,
    parameter int AREA = 8,
    localparam int LW    = $clog2(regwin_pkg::N_AREAS * AREA),
    localparam int OW    = $clog2(AREA),
    localparam int WPW   = $clog2(NWIN),
    localparam int DEPTH = AREA + NWIN * 2 * AREA,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic [LW-1:0]  lreg_i,
    input  logic [WPW-1:0] win_i,
    output logic [PW-1:0]  preg_o
);

    logic [WPW-1:0] win_nx;
    int             off;

    always_comb begin
        win_nx = (win_i == WPW'(NWIN - 1)) ? '0 : win_i + 1'b1;
        off    = int'(lreg_i[OW-1:0]);
        unique case (lreg_i[LW-1:OW])
            2'd0:    preg_o = PW'(off);
            2'd1:    preg_o = PW'(AREA + int'(win_i) * 2 * AREA + off);
            2'd2:    preg_o = PW'(AREA + int'(win_i) * 2 * AREA + AREA + off);
            2'd3:    preg_o = PW'(AREA + int'(win_nx) * 2 * AREA + off);
            default: preg_o = '0;
        endcase
    end

endmodule

// File: rtl/regwin_store.sv
`timescale 1ns/1ps
// Physical register storage: NRD combinational read ports, one write port.
module regwin_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 136,
    parameter int NRD   = 3,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [PW-1:0]           waddr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [NRD-1:0][PW-1:0]  raddr_i,
    output logic [NRD-1:0][DW-1:0]  rdata_o
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata_o[g] = mem[raddr_i[g]];
    end

endmodule

// File: rtl/regwin_ctrl.sv
`timescale 1ns/1ps
// Window pointer state machine with spill/fill sequencing.
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AREA = 8,
    localparam int WPW   = $clog2(NWIN),
    localparam int CW    = $clog2(2 * AREA),
    localparam int DEPTH = AREA + NWIN * 2 * AREA,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           spill_ready_i,
    input  logic           fill_valid_i,
    output logic           busy_o,
    output logic           user_ok_o,
    output logic           ovf_trap_o,
    output logic           unf_trap_o,
    output logic [WPW-1:0] cwp_o,
    output logic [WPW-1:0] swp_o,
    output logic           spill_valid_o,
    output logic           fill_ready_o,
    output logic           fill_we_o,
    output logic [PW-1:0]  xfer_addr_o
);

    win_state_t     state_q, state_d;
    logic [WPW-1:0] cwp_q, swp_q, cwp_inc, cwp_dec, swp_inc, swp_dec, xfer_win;
    logic [CW-1:0]  cnt_q;
    logic           ovf_q, unf_q;
    logic           ovf_hit, unf_hit, beat, last;

    always_comb begin
        cwp_inc  = (cwp_q == WPW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
        cwp_dec  = (cwp_q == '0) ? WPW'(NWIN - 1) : cwp_q - 1'b1;
        swp_inc  = (swp_q == WPW'(NWIN - 1)) ? '0 : swp_q + 1'b1;
        swp_dec  = (swp_q == '0) ? WPW'(NWIN - 1) : swp_q - 1'b1;
        ovf_hit  = (cwp_inc == swp_q);
        unf_hit  = (cwp_dec == swp_q);
        last     = (cnt_q == CW'(2 * AREA - 1));
        beat     = ((state_q == ST_SPILL) && spill_ready_i) ||
                   ((state_q == ST_FILL) && fill_valid_i);
        xfer_win = (state_q == ST_SPILL) ? swp_inc : swp_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (call_i && ovf_hit)                state_d = ST_SPILL;
                else if (!call_i && ret_i && unf_hit) state_d = ST_FILL;
            end
            ST_SPILL, ST_FILL: begin
                if (beat && last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pointers, beat counter and trap pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= '0;
            swp_q <= WPW'(NWIN - 1);
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= (state_q == ST_IDLE) && call_i && ovf_hit;
            unf_q <= (state_q == ST_IDLE) && !call_i && ret_i && unf_hit;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (call_i) begin
                        if (!ovf_hit) cwp_q <= cwp_inc;
                    end else if (ret_i && !unf_hit) begin
                        cwp_q <= cwp_dec;
                    end
                end
                ST_SPILL: begin
                    if (beat) begin
                        cnt_q <= last ? '0 : cnt_q + 1'b1;
                        if (last) begin
                            cwp_q <= cwp_inc;
                            swp_q <= swp_inc;
                        end
                    end
                end
                ST_FILL: begin
                    if (beat) begin
                        cnt_q <= last ? '0 : cnt_q + 1'b1;
                        if (last) begin
                            cwp_q <= cwp_dec;
                            swp_q <= swp_dec;
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o        = 1'b0;
        user_ok_o     = 1'b0;
        spill_valid_o = 1'b0;
        fill_ready_o  = 1'b0;
        fill_we_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:  user_ok_o = 1'b1;
            ST_SPILL: begin
                busy_o        = 1'b1;
                spill_valid_o = 1'b1;
            end
            ST_FILL: begin
                busy_o       = 1'b1;
                fill_ready_o = 1'b1;
                fill_we_o    = fill_valid_i;
            end
            default: user_ok_o = 1'b0;
        endcase
        cwp_o       = cwp_q;
        swp_o       = swp_q;
        ovf_trap_o  = ovf_q;
        unf_trap_o  = unf_q;
        xfer_addr_o = PW'(AREA + int'(xfer_win) * 2 * AREA + int'(cnt_q));
    end

    // The current window never coincides with the saved window (R3)
    a_r3_ring_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_q != swp_q);

    // Pointers frozen while a transfer runs, except on its final beat (R7)
    a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !(beat && last)) |=> ($stable(cwp_q) && $stable(swp_q)));

    // Overflow trap coincides with a running spill and is a single pulse (R5)
    a_r5_trap_spill: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> spill_valid_o);
    a_r5_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);

    // Underflow trap coincides with a running fill (R6)
    a_r6_trap_fill: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> fill_ready_o);

endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
// Windowed register file: top level.
module regwin_file #(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    parameter int AREA = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             call_i,
    input  logic                             ret_i,
    input  logic                             wr_en_i,
    input  logic [$clog2(4*AREA)-1:0]        wr_reg_i,
    input  logic [DW-1:0]                    wr_data_i,
    input  logic [$clog2(4*AREA)-1:0]        rd0_reg_i,
    output logic [DW-1:0]                    rd0_data_o,
    input  logic [$clog2(4*AREA)-1:0]        rd1_reg_i,
    output logic [DW-1:0]                    rd1_data_o,
    output logic                             busy_o,
    output logic                             ovf_trap_o,
    output logic                             unf_trap_o,
    output logic [$clog2(NWIN)-1:0]          cwp_o,
    output logic [$clog2(NWIN)-1:0]          swp_o,
    output logic                             spill_valid_o,
    input  logic                             spill_ready_i,
    output logic [DW-1:0]                    spill_data_o,
    input  logic                             fill_valid_i,
    output logic                             fill_ready_o,
    input  logic [DW-1:0]                    fill_data_i
);

    localparam int LW    = $clog2(4 * AREA);
    localparam int DEPTH = AREA + NWIN * 2 * AREA;
    localparam int PW    = $clog2(DEPTH);
    localparam int NRD   = 3;   // two user read ports plus the spill port

    logic                   user_ok, fill_we, user_we, st_we;
    logic [PW-1:0]          xfer_addr, wr_p, st_waddr;
    logic [DW-1:0]          st_wdata;
    logic [1:0][LW-1:0]     rd_l;
    logic [NRD-1:0][PW-1:0] rd_p;
    logic [NRD-1:0][DW-1:0] rd_d;

    regwin_ctrl #(.NWIN(NWIN), .AREA(AREA)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_i        (call_i),
        .ret_i         (ret_i),
        .spill_ready_i (spill_ready_i),
        .fill_valid_i  (fill_valid_i),
        .busy_o        (busy_o),
        .user_ok_o     (user_ok),
        .ovf_trap_o    (ovf_trap_o),
        .unf_trap_o    (unf_trap_o),
        .cwp_o         (cwp_o),
        .swp_o         (swp_o),
        .spill_valid_o (spill_valid_o),
        .fill_ready_o  (fill_ready_o),
        .fill_we_o     (fill_we),
        .xfer_addr_o   (xfer_addr)
    );

    assign rd_l[0] = rd0_reg_i;
    assign rd_l[1] = rd1_reg_i;

    for (genvar g = 0; g < 2; g++) begin : g_rmap
        regwin_map #(.NWIN(NWIN), .AREA(AREA)) u_rmap (
            .lreg_i (rd_l[g]),
            .win_i  (cwp_o),
            .preg_o (rd_p[g])
        );
    end
    assign rd_p[2] = xfer_addr;

    regwin_map #(.NWIN(NWIN), .AREA(AREA)) u_wmap (
        .lreg_i (wr_reg_i),
        .win_i  (cwp_o),
        .preg_o (wr_p)
    );

    assign user_we  = wr_en_i && user_ok && (wr_reg_i != '0);
    assign st_we    = fill_we || user_we;
    assign st_waddr = fill_we ? xfer_addr : wr_p;
    assign st_wdata = fill_we ? fill_data_i : wr_data_i;

    regwin_store #(.DW(DW), .DEPTH(DEPTH), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .waddr_i (st_waddr),
        .wdata_i (st_wdata),
        .raddr_i (rd_p),
        .rdata_o (rd_d)
    );

    assign rd0_data_o   = rd_d[0];
    assign rd1_data_o   = rd_d[1];
    assign spill_data_o = rd_d[2];

    // Physical slot 0 (logical register 0) is never written (R2)
    a_r2_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (st_waddr != '0));

    // A stalled spill word stays valid and unchanged (R5)
    a_r5_spill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_valid_o && !spill_ready_i) |=> (spill_valid_o && $stable(spill_data_o)));

    // User writes never reach storage while busy (R7)
    a_r7_no_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fill_we) |-> !st_we);

endmodule

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;

    localparam int NW = 8;
    localparam int AR = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          call, ret, wr_en, sready, fvalid;
    logic [4:0]    wr_reg, rd0_reg, rd1_reg;
    logic [DW-1:0] wr_data, fdata;
    logic [DW-1:0] rd0_data, rd1_data, spill_data;
    logic          busy, ovf, unf, spill_valid, fill_ready;
    logic [2:0]    cwp, swp;

    always #5 clk = ~clk;

    regwin_file i_regwin_file (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_i        (call),
        .ret_i         (ret),
        .wr_en_i       (wr_en),
        .wr_reg_i      (wr_reg),
        .wr_data_i     (wr_data),
        .rd0_reg_i     (rd0_reg),
        .rd0_data_o    (rd0_data),
        .rd1_reg_i     (rd1_reg),
        .rd1_data_o    (rd1_data),
        .busy_o        (busy),
        .ovf_trap_o    (ovf),
        .unf_trap_o    (unf),
        .cwp_o         (cwp),
        .swp_o         (swp),
        .spill_valid_o (spill_valid),
        .spill_ready_i (sready),
        .spill_data_o  (spill_data),
        .fill_valid_i  (fvalid),
        .fill_ready_o  (fill_ready),
        .fill_data_i   (fdata)
    );

    // Reference model state
    int          m_cwp, m_swp, m_mode, m_cnt;   // mode: 0 idle, 1 spill, 2 fill
    bit          m_ovf, m_unf;
    logic [31:0] m_par [NW][AR];
    logic [31:0] m_loc [NW][AR];
    logic [31:0] m_glb [AR];
    logic [31:0] stk [$];

    int    n_chk = 0, n_err = 0, cycn = 0, pin_ra0 = -1;
    int    ra0, ra1;
    string rd_tag = "";

    function automatic logic [31:0] mread(int l);
        if (l == 0)       return '0;
        else if (l < 8)   return m_glb[l];
        else if (l < 16)  return m_par[m_cwp][l-8];
        else if (l < 24)  return m_loc[m_cwp][l-16];
        else              return m_par[(m_cwp+1)%NW][l-24];
    endfunction

    function automatic void mwrite(int l, logic [31:0] d);
        if (l == 0)       return;
        else if (l < 8)   m_glb[l] = d;
        else if (l < 16)  m_par[m_cwp][l-8] = d;
        else if (l < 24)  m_loc[m_cwp][l-16] = d;
        else              m_par[(m_cwp+1)%NW][l-24] = d;
    endfunction

    function automatic logic [31:0] spill_word();
        int w = (m_swp + 1) % NW;
        return (m_cnt < AR) ? m_par[w][m_cnt] : m_loc[w][m_cnt-AR];
    endfunction

    function automatic string tag_of(int l);
        if (l == 0)      return "R2";
        else if (l < 8)  return "R4";
        else if (l < 24) return "R1";
        else             return "R11";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cycn, act, exp);
        end
    endtask

    task automatic compare();
        chk((rd_tag != "") ? rd_tag : tag_of(ra0), rd0_data, mread(ra0));
        chk("R10", rd1_data, mread(ra1));
        chk("R3", 32'(cwp), 32'(m_cwp));
        chk("R3", 32'(swp), 32'(m_swp));
        chk("R7", 32'(busy), 32'(m_mode != 0));
        chk("R5", 32'(ovf), 32'(m_ovf));
        chk("R6", 32'(unf), 32'(m_unf));
        chk("R5", 32'(spill_valid), 32'(m_mode == 1));
        if (m_mode == 1) chk("R5", spill_data, spill_word());
        chk("R6", 32'(fill_ready), 32'(m_mode == 2));
    endtask

    task automatic update(bit c, bit r, bit w, int wa, logic [31:0] wd);
        m_ovf = 1'b0;
        m_unf = 1'b0;
        case (m_mode)
            0: begin
                if (w) mwrite(wa, wd);            // R8: write before the move
                if (c) begin
                    if ((m_cwp + 1) % NW == m_swp) begin
                        m_mode = 1; m_cnt = 0; m_ovf = 1'b1;
                    end else m_cwp = (m_cwp + 1) % NW;
                end else if (r) begin
                    if ((m_cwp + NW - 1) % NW == m_swp) begin
                        m_mode = 2; m_cnt = 0; m_unf = 1'b1;
                    end else m_cwp = (m_cwp + NW - 1) % NW;
                end
            end
            1: if (sready) begin
                stk.push_back(spill_word());
                if (m_cnt == 2*AR-1) begin
                    m_mode = 0; m_cnt = 0;
                    m_swp = (m_swp + 1) % NW;
                    m_cwp = (m_cwp + 1) % NW;
                end else m_cnt++;
            end
            default: if (fvalid) begin
                if (m_cnt < AR) m_par[m_swp][m_cnt] = fdata;
                else            m_loc[m_swp][m_cnt-AR] = fdata;
                if (m_cnt == 2*AR-1) begin
                    if (stk.size() >= 2*AR)
                        for (int k = 0; k < 2*AR; k++) void'(stk.pop_back());
                    m_mode = 0; m_cnt = 0;
                    m_swp = (m_swp + NW - 1) % NW;
                    m_cwp = (m_cwp + NW - 1) % NW;
                end else m_cnt++;
            end
        endcase
    endtask

    task automatic cyc(bit c, bit r, bit w, int wa, logic [31:0] wd);
        @(negedge clk);
        cycn++;
        call = c; ret = r; wr_en = w; wr_reg = 5'(wa); wr_data = wd;
        ra0 = (pin_ra0 >= 0) ? pin_ra0 : cycn % 32;
        ra1 = (cycn * 7 + 3) % 32;
        rd0_reg = 5'(ra0);
        rd1_reg = 5'(ra1);
        sready = (cycn % 3) != 2;
        fvalid = (cycn % 4) != 1;
        if (m_mode == 2 && stk.size() >= 2*AR) fdata = stk[stk.size() - 2*AR + m_cnt];
        else                                   fdata = 32'hF111_0000 + 32'(cycn);
        #1 compare();
        @(posedge clk);
        update(c, r, w, wa, wd);
    endtask

    // Drive conflicting requests while a transfer runs (R7)
    task automatic drain();
        while (m_mode != 0) cyc(1'b1, cycn[0], 1'b1, 17, 32'hDEAD_0000 + 32'(cycn));
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL R7 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned st;
        rst_n = 1'b0; call = 0; ret = 0; wr_en = 0; wr_reg = 0; wr_data = 0;
        rd0_reg = 5'd16; rd1_reg = 5'd24; sready = 0; fvalid = 0; fdata = 0;
        m_cwp = 0; m_swp = NW - 1; m_mode = 0; m_cnt = 0; m_ovf = 0; m_unf = 0;
        for (int w = 0; w < NW; w++)
            for (int k = 0; k < AR; k++) begin
                m_par[w][k] = '0;
                m_loc[w][k] = '0;
            end
        for (int k = 0; k < AR; k++) m_glb[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9", 32'(busy), 0);
        chk("R9", 32'(cwp), 0);
        chk("R9", 32'(swp), 7);
        chk("R9", 32'(ovf | unf), 0);
        chk("R9", rd0_data, 0);
        chk("R9", rd1_data, 0);

        // Globals and register 0 (R2, R4)
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, i, 32'hA000_0000 + 32'(i));

        // Twelve-deep call chain: overflows and spills (R5, R11)
        for (int d = 0; d < 12; d++) begin
            cyc(0, 0, 1, 16 + d % 8, 32'hB000_0000 + 32'(d));
            cyc(0, 0, 1, 24 + d % 8, 32'hC000_0000 + 32'(d));
            cyc(0, 0, 1, 8 + d % 8,  32'hD000_0000 + 32'(d));
            cyc(1, 0, 0, 0, 0);
            drain();
            for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0);
        end

        // Unwind past the spilled windows: underflows and fills (R6)
        for (int d = 0; d < 14; d++) begin
            cyc(0, 1, 0, 0, 0);
            drain();
            for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0);
        end

        // R8: call and return together, write in the same cycle
        cyc(1, 1, 1, 24, 32'h8888_0001);
        drain();
        rd_tag = "R8"; pin_ra0 = 8;
        cyc(0, 0, 0, 0, 0);
        rd_tag = ""; pin_ra0 = -1;
        cyc(0, 1, 1, 16, 32'h8888_0002);
        drain();
        cyc(0, 0, 0, 0, 0);

        // Pseudo-random mix
        st = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            st = st * 1103515245 + 12345;
            cyc(((st >> 16) % 5) == 0, ((st >> 20) % 5) == 0, st[8],
                int'((st >> 24) % 32), st);
        end
        drain();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule